// File: doc/BRIEF.md
# Reset Cause Status Flags

This block holds four sticky status bits that let software work out why the processor last came out of reset. Two of them form a small software-visible control byte: a power-up indicator and a supply-dip indicator. The other two record whether the watchdog expired (the time-out bit) and whether the core was asleep (the power-down bit).

Each reset source arrives as a one-cycle strobe from detectors outside the block. Each source changes its own subset of the bits and leaves the rest alone, so a later read reveals the cause. Hardware can only clear the power-up and supply-dip bits. Software sets them again through a write port, so that a later 0 stands out.

Sleep entry and watchdog refresh strobes also update the time-out and power-down bits. All updates appear on the outputs one clock after the strobe.

Top module: `rst_cause_flags`

## Requirements
- R1: A power-on strobe, or the asynchronous `rst_n`, leaves the power-up bit 0, the supply-dip bit 0 (the value chosen to model its undefined power-on state), the time-out bit 1 and the power-down bit 1.
- R2: A brown-out strobe clears the supply-dip bit and sets the time-out and power-down bits. The power-up bit is unchanged.
- R3: A watchdog reset in normal operation clears the time-out bit. The power-down bit and both control bits are unchanged.
- R4: A watchdog wake-up from sleep clears both the time-out and power-down bits.
- R5: An external pin reset in normal operation changes no bit.
- R6: An external pin reset during sleep sets the time-out bit and clears the power-down bit.
- R7: A sleep strobe sets the time-out bit and clears the power-down bit. A watchdog-clear strobe sets both bits.
- R8: A software write with no reset strobe in the same cycle loads `sw_wr_data[1]` into the power-up bit and `sw_wr_data[0]` into the supply-dip bit. The time-out and power-down bits are unaffected by the write.
- R9: A software write in the same cycle as any of the six reset strobes is discarded.
- R10: `ctrl_rd` shows the power-up bit at position 1 and the supply-dip bit at position 0. All higher positions read 0.
- R11: Simultaneous strobes resolve in this priority order: power-on, brown-out, watchdog reset, watchdog wake-up, pin reset in sleep, pin reset in run, watchdog clear, sleep. Only the winning strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as power-on |
| ev_pwr_on | input | 1 | Power-on reset strobe |
| ev_brownout | input | 1 | Brown-out reset strobe |
| ev_wdt_reset | input | 1 | Watchdog reset during normal operation |
| ev_wdt_wake | input | 1 | Watchdog wake-up from sleep |
| ev_pin_run | input | 1 | External pin reset during normal operation |
| ev_pin_sleep | input | 1 | External pin reset during sleep |
| sleep_cmd | input | 1 | Sleep instruction executed |
| wdt_clear | input | 1 | Watchdog clear instruction executed |
| sw_wr_en | input | 1 | Software write strobe for the control byte |
| sw_wr_data | input | 2 | Write data: bit 1 power-up, bit 0 supply-dip |
| ctrl_rd | output | CTRL_W | Readable control byte |
| flag_timeout | output | 1 | Time-out bit |
| flag_pdown | output | 1 | Power-down bit |

## Verification
The checker assumes that every strobe and the write port are synchronous to `clk` and stable around the sampling edge. It also assumes that `rst_n` is low at time zero, so that no property sees uninitialised state. Each property guards its antecedent against higher-priority strobes, so it claims nothing the priority rule would override. The directed bench drives all inputs on the falling edge and samples one falling edge later. It combines strobes only in the collision cases it deliberately targets for the priority and write-blocking rules.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int NUM_SRC = 8;
    localparam int PON_POS = 1;
    localparam int BOR_POS = 0;
    localparam int EV_W    = $clog2(NUM_SRC + 1);

    // Value = priority index + 1; lower value wins.
    typedef enum logic [EV_W-1:0] {
        EV_NONE      = 4'd0,
        EV_POR       = 4'd1,
        EV_BOR       = 4'd2,
        EV_WDT_RST   = 4'd3,
        EV_WDT_WAKE  = 4'd4,
        EV_PIN_SLEEP = 4'd5,
        EV_PIN_RUN   = 4'd6,
        EV_WDT_CLR   = 4'd7,
        EV_SLEEP     = 4'd8
    } event_e;

    typedef struct packed {
        logic pon;
        logic bor;
        logic tmo;
        logic pdn;
    } flags_t;

    // Supply-dip bit is undefined at power-on; modelled as 0.
    localparam flags_t FLAGS_PWRUP = '{pon: 1'b0, bor: 1'b0, tmo: 1'b1, pdn: 1'b1};

    function automatic logic is_reset(event_e e);
        return (e >= EV_POR) && (e <= EV_PIN_RUN);
    endfunction

endpackage

// File: rtl/rcf_event_select.sv
module rcf_event_select #(
    parameter int N = rcf_pkg::NUM_SRC
) (
    input  logic [N-1:0]    req_i,
    output rcf_pkg::event_e ev_o
);
    import rcf_pkg::*;

    always_comb begin
        ev_o = EV_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                ev_o = event_e'(EV_W'(i + 1));
            end
        end
    end

endmodule

// File: rtl/rcf_flag_update.sv
module rcf_flag_update (
    input  rcf_pkg::event_e ev_i,
    input  rcf_pkg::flags_t cur_i,
    output rcf_pkg::flags_t nxt_o
);
    import rcf_pkg::*;

    always_comb begin
        nxt_o = cur_i;
        unique case (ev_i)
            EV_POR:       nxt_o = FLAGS_PWRUP;
            EV_BOR: begin
                nxt_o.bor = 1'b0;
                nxt_o.tmo = 1'b1;
                nxt_o.pdn = 1'b1;
            end
            EV_WDT_RST:   nxt_o.tmo = 1'b0;
            EV_WDT_WAKE: begin
                nxt_o.tmo = 1'b0;
                nxt_o.pdn = 1'b0;
            end
            EV_PIN_SLEEP, EV_SLEEP: begin
                nxt_o.tmo = 1'b1;
                nxt_o.pdn = 1'b0;
            end
            EV_WDT_CLR: begin
                nxt_o.tmo = 1'b1;
                nxt_o.pdn = 1'b1;
            end
            default:      nxt_o = cur_i;  // EV_NONE, EV_PIN_RUN
        endcase
    end

endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_pwr_on,
    input  logic              ev_brownout,
    input  logic              ev_wdt_reset,
    input  logic              ev_wdt_wake,
    input  logic              ev_pin_run,
    input  logic              ev_pin_sleep,
    input  logic              sleep_cmd,
    input  logic              wdt_clear,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_data,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              flag_timeout,
    output logic              flag_pdown
);
    import rcf_pkg::*;

    logic [NUM_SRC-1:0] req;
    event_e             ev_sel;
    flags_t             upd;
    flags_t             flags_d, flags_q;

    // Index 0 is the highest priority.
    assign req = {sleep_cmd, wdt_clear, ev_pin_run, ev_pin_sleep,
                  ev_wdt_wake, ev_wdt_reset, ev_brownout, ev_pwr_on};

    rcf_event_select #(.N(NUM_SRC)) u_sel (
        .req_i (req),
        .ev_o  (ev_sel)
    );

    rcf_flag_update u_upd (
        .ev_i  (ev_sel),
        .cur_i (flags_q),
        .nxt_o (upd)
    );

    always_comb begin
        flags_d = upd;
        if (sw_wr_en && !is_reset(ev_sel)) begin
            flags_d.pon = sw_wr_data[PON_POS];
            flags_d.bor = sw_wr_data[BOR_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= FLAGS_PWRUP;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[PON_POS] = flags_q.pon;
        ctrl_rd[BOR_POS] = flags_q.bor;
    end

    assign flag_timeout = flags_q.tmo;
    assign flag_pdown   = flags_q.pdn;

endmodule

// File: rtl/rcf_checker.sv
module rcf_checker #(
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_pwr_on,
    input logic              ev_brownout,
    input logic              ev_wdt_reset,
    input logic              ev_wdt_wake,
    input logic              ev_pin_run,
    input logic              ev_pin_sleep,
    input logic              sleep_cmd,
    input logic              wdt_clear,
    input logic              sw_wr_en,
    input logic [1:0]        sw_wr_data,
    input logic [CTRL_W-1:0] ctrl_rd,
    input logic              flag_timeout,
    input logic              flag_pdown
);
    logic any_rst, pon, bor;
    assign any_rst = ev_pwr_on | ev_brownout | ev_wdt_reset | ev_wdt_wake
                   | ev_pin_run | ev_pin_sleep;
    assign pon = ctrl_rd[1];
    assign bor = ctrl_rd[0];

    assert_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwr_on |=> !pon && !bor && flag_timeout && flag_pdown);

    assert_bor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_brownout && !ev_pwr_on |=>
            !bor && flag_timeout && flag_pdown && pon == $past(pon));

    assert_wdt_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_reset && !ev_pwr_on && !ev_brownout |=>
            !flag_timeout && flag_pdown == $past(flag_pdown)
            && ctrl_rd == $past(ctrl_rd));

    assert_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_wake && !ev_pwr_on && !ev_brownout && !ev_wdt_reset |=>
            !flag_timeout && !flag_pdown);

    assert_pin_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pin_run && !ev_pwr_on && !ev_brownout && !ev_wdt_reset
            && !ev_wdt_wake && !ev_pin_sleep |=>
            $stable(ctrl_rd) && $stable(flag_timeout) && $stable(flag_pdown));

    assert_pin_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pin_sleep && !ev_pwr_on && !ev_brownout && !ev_wdt_reset
            && !ev_wdt_wake |=> flag_timeout && !flag_pdown);

    assert_wdt_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear && !any_rst |=> flag_timeout && flag_pdown);

    assert_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_cmd && !wdt_clear && !any_rst |=> flag_timeout && !flag_pdown);

    assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && !any_rst |=>
            pon == $past(sw_wr_data[1]) && bor == $past(sw_wr_data[0]));

    assert_write_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && ev_wdt_reset && !ev_pwr_on && !ev_brownout |=>
            ctrl_rd == $past(ctrl_rd));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd >> 2) == '0);

    assert_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_wake && ev_pin_sleep && !ev_pwr_on && !ev_brownout
            && !ev_wdt_reset |=> !flag_timeout);

endmodule

bind rst_cause_flags rcf_checker #(.CTRL_W(CTRL_W)) u_rcf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_pwr_on    (ev_pwr_on),
    .ev_brownout  (ev_brownout),
    .ev_wdt_reset (ev_wdt_reset),
    .ev_wdt_wake  (ev_wdt_wake),
    .ev_pin_run   (ev_pin_run),
    .ev_pin_sleep (ev_pin_sleep),
    .sleep_cmd    (sleep_cmd),
    .wdt_clear    (wdt_clear),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .ctrl_rd      (ctrl_rd),
    .flag_timeout (flag_timeout),
    .flag_pdown   (flag_pdown)
);

// File: tb/test_rst_cause_flags.sv
`timescale 1ns/1ps
module test_rst_cause_flags;
    localparam int CTRL_W = 8;

    // Strobe bit positions inside the bench's stimulus vector.
    localparam logic [7:0] S_POR   = 8'h01;
    localparam logic [7:0] S_BOR   = 8'h02;
    localparam logic [7:0] S_WRST  = 8'h04;
    localparam logic [7:0] S_WAKE  = 8'h08;
    localparam logic [7:0] S_PSLP  = 8'h10;
    localparam logic [7:0] S_PRUN  = 8'h20;
    localparam logic [7:0] S_CLR   = 8'h40;
    localparam logic [7:0] S_SLEEP = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] strb = '0;
    logic sw_wr_en = 1'b0;
    logic [1:0] sw_wr_data = '0;
    logic [CTRL_W-1:0] ctrl_rd;
    logic flag_timeout, flag_pdown;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rst_cause_flags #(.CTRL_W(CTRL_W)) i_rst_cause_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_pwr_on    (strb[0]),
        .ev_brownout  (strb[1]),
        .ev_wdt_reset (strb[2]),
        .ev_wdt_wake  (strb[3]),
        .ev_pin_sleep (strb[4]),
        .ev_pin_run   (strb[5]),
        .wdt_clear    (strb[6]),
        .sleep_cmd    (strb[7]),
        .sw_wr_en     (sw_wr_en),
        .sw_wr_data   (sw_wr_data),
        .ctrl_rd      (ctrl_rd),
        .flag_timeout (flag_timeout),
        .flag_pdown   (flag_pdown)
    );

    task automatic expect_state(string req, logic [CTRL_W-1:0] e_ctrl, logic e_to, logic e_pd);
        checks++;
        if (ctrl_rd !== e_ctrl || flag_timeout !== e_to || flag_pdown !== e_pd) begin
            errors++;
            $display("FAIL %s: ctrl=%h to=%b pd=%b, expected ctrl=%h to=%b pd=%b",
                     req, ctrl_rd, flag_timeout, flag_pdown, e_ctrl, e_to, e_pd);
        end
    endtask

    task automatic step(logic [7:0] s, logic wr, logic [1:0] d);
        @(negedge clk);
        strb = s; sw_wr_en = wr; sw_wr_data = d;
        @(negedge clk);
        strb = '0; sw_wr_en = 1'b0; sw_wr_data = '0;
    endtask

    task automatic t_reset_state;
        expect_state("R1/R10 reset", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_sw_write;
        step('0, 1'b1, 2'b01);
        expect_state("R8 write 01", 8'h01, 1'b1, 1'b1);
        step('0, 1'b1, 2'b11);
        expect_state("R8/R10 write 11", 8'h03, 1'b1, 1'b1);
    endtask

    task automatic t_watchdog;
        step(S_WRST, 1'b0, 2'b00);
        expect_state("R3 wdt reset", 8'h03, 1'b0, 1'b1);
        step(S_CLR, 1'b0, 2'b00);
        expect_state("R7 wdt clear", 8'h03, 1'b1, 1'b1);
        step(S_SLEEP, 1'b0, 2'b00);
        expect_state("R7 sleep", 8'h03, 1'b1, 1'b0);
        step(S_WAKE, 1'b0, 2'b00);
        expect_state("R4 wdt wake", 8'h03, 1'b0, 1'b0);
    endtask

    task automatic t_pin;
        step(S_PSLP, 1'b0, 2'b00);
        expect_state("R6 pin in sleep", 8'h03, 1'b1, 1'b0);
        step(S_PRUN, 1'b1, 2'b00);
        expect_state("R5/R9 pin in run", 8'h03, 1'b1, 1'b0);
    endtask

    task automatic t_brownout;
        step(S_BOR, 1'b1, 2'b11);
        expect_state("R2/R9 brown-out", 8'h02, 1'b1, 1'b1);
        step('0, 1'b1, 2'b11);
        expect_state("R8 rewrite", 8'h03, 1'b1, 1'b1);
    endtask

    task automatic t_priority;
        step(S_WAKE | S_PSLP | S_SLEEP, 1'b0, 2'b00);
        expect_state("R11 wake over pin sleep", 8'h03, 1'b0, 1'b0);
        step(S_CLR | S_SLEEP, 1'b0, 2'b00);
        expect_state("R11 clear over sleep", 8'h03, 1'b1, 1'b1);
        step(S_SLEEP, 1'b0, 2'b00);
        step(S_PRUN | S_CLR, 1'b0, 2'b00);
        expect_state("R11 pin run over clear", 8'h03, 1'b1, 1'b0);
        step(S_POR | S_BOR | S_WRST, 1'b1, 2'b11);
        expect_state("R1/R11 power-on wins", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_async_reset;
        step(S_WRST, 1'b0, 2'b00);
        step('0, 1'b1, 2'b10);
        expect_state("R8 write 10", 8'h02, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        expect_state("R1 async reset", 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_sw_write();
        t_watchdog();
        t_pin();
        t_brownout();
        t_priority();
        t_async_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule